// File: doc/BRIEF.md
# Distinct-Count Bitmap Estimator Readout

This block turns a bank of probabilistic counting bitmaps into a distinct-value estimate. Each bitmap records hashed items: a bit is set when a hash with that trailing-zero run length has been seen. After a one-cycle start request, the block reads the 2^B bitmaps in address order, one per clock. For each bitmap it finds the lowest bit still at zero and adds that index into an accumulator.

Once the sweep ends, the accumulator holds the sum of the observables. Its low B bits are the fraction of the arithmetic mean. The block then forms the estimate (2^B / 0.77351) · 2^mean in fixed point. The integer part of the mean becomes a left shift. The top four fraction bits select a constant from a 16-entry table, and that constant already includes the 1/0.77351 factor.

The raw sum and the estimate are presented together with a sticky done flag. A caller pulses start, supplies bitmap words on the read port, and collects both results when done rises. Results are poor when the count is only 10 to 20 times the number of bitmaps. No correction for that region is applied here.

Top module: `lowzero_card_est`

## Requirements
- R1: After reset, busy and done are 0 and obs_sum and estimate are 0.
- R2: The observable of a bitmap is the index of its lowest 0 bit, counting bit 0 as the least significant; a bitmap with all W bits set contributes W.
- R3: While busy, rd_addr steps 0, 1, ..., 2^B-1 on successive cycles, and rd_data is sampled in the same cycle. obs_sum ends as the sum of the observables of all 2^B words and never exceeds 2^B·W.
- R4: A start seen while idle is accepted at that clock edge, and busy is high from the following cycle. done rises exactly 2^B+1 cycles after the accepting edge and busy falls with it. done is cleared when a start is accepted and otherwise stays high.
- R5: A start asserted while busy is ignored: the sweep, its timing and its results are unaffected.
- R6: With I = obs_sum >> B and F = the top 4 bits of obs_sum[B-1:0], estimate equals floor(2^B/0.77351 · 2^(I+F/16)) to within 0.2% plus 2 counts.
- R7: When that value exceeds 2^EW-1, estimate is all ones instead of wrapping.
- R8: While idle and without a start, obs_sum and estimate hold their values whatever rd_data does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a sweep (honoured only when idle) |
| rd_addr | output | B | Index of the bitmap being read |
| rd_data | input | W | Bitmap word at rd_addr, valid in the same cycle |
| busy | output | 1 | Sweep or final scaling in progress |
| done | output | 1 | Results valid; held until the next accepted start |
| obs_sum | output | B+clog2(W+1) | Sum of the lowest-zero indices |
| estimate | output | EW | Saturating distinct-value estimate |

## Verification
Two situations are hard to reach from the ports: saturation of the estimate, and a start that collides with a running sweep. Saturation only occurs when nearly every bitmap is filled up to bit 28 or beyond. Uniformly random words almost never get there, so directed banks with every observable set to 27, 28 and W sit on both sides of the limit. The collision is produced by raising start several cycles into a sweep and then checking that the latency and the results match an undisturbed sweep. Random banks use a chosen lowest-zero position with random bits above it, so the observable is varied independently of the upper noise.

// File: rtl/lowzero_card_est.sv
module lowzero_card_est #(
  parameter int B  = 4,
  parameter int W  = 32,
  parameter int EW = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  output logic [B-1:0]                      rd_addr,
  input  logic [W-1:0]                      rd_data,
  output logic                              busy,
  output logic                              done,
  output logic [B+$clog2(W+1)-1:0]          obs_sum,
  output logic [EW-1:0]                     estimate
);
  localparam int M  = 1 << B;
  localparam int OW = $clog2(W + 1);
  localparam int SW = B + OW;
  localparam int TW = 18;
  localparam int FB = 16;
  localparam int PW = TW + W + B;

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_FINAL} st_t;

  st_t            st;
  logic [B-1:0]   idx;
  logic [SW-1:0]  sum;
  logic [EW-1:0]  est;
  logic           done_q;

  function automatic logic [OW-1:0] low_zero(input logic [W-1:0] v);
    low_zero = OW'(W);
    for (int i = W - 1; i >= 0; i--)
      if (!v[i]) low_zero = OW'(i);
  endfunction

  function automatic logic [TW-1:0] frac_pow(input logic [3:0] f);
    case (f)
      4'd0:  frac_pow = 18'd84725;
      4'd1:  frac_pow = 18'd88477;
      4'd2:  frac_pow = 18'd92394;
      4'd3:  frac_pow = 18'd96484;
      4'd4:  frac_pow = 18'd100756;
      4'd5:  frac_pow = 18'd105217;
      4'd6:  frac_pow = 18'd109875;
      4'd7:  frac_pow = 18'd114740;
      4'd8:  frac_pow = 18'd119820;
      4'd9:  frac_pow = 18'd125125;
      4'd10: frac_pow = 18'd130665;
      4'd11: frac_pow = 18'd136450;
      4'd12: frac_pow = 18'd142491;
      4'd13: frac_pow = 18'd148799;
      4'd14: frac_pow = 18'd155387;
      default: frac_pow = 18'd162267;
    endcase
  endfunction

  wire [OW-1:0]    int_part = sum[SW-1:B];
  wire [3:0]       frac     = sum[B-1 -: 4];
  wire [OW+4:0]    shamt    = (OW+5)'(int_part) + (OW+5)'(B);
  wire [PW-1:0]    scaled   = PW'(frac_pow(frac)) << shamt;
  wire [PW-FB-1:0] est_full = scaled[PW-1:FB];
  wire             ovf      = (est_full >> EW) != '0;
  wire [EW-1:0]    est_next = ovf ? '1 : EW'(est_full);

  assign rd_addr  = idx;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign obs_sum  = sum;
  assign estimate = est;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      sum    <= '0;
      est    <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SWEEP;
          idx    <= '0;
          sum    <= '0;
          done_q <= 1'b0;
        end
        S_SWEEP: begin
          sum <= sum + SW'(low_zero(rd_data));
          if (idx == B'(M - 1)) st <= S_FINAL;
          else                  idx <= idx + 1'b1;
        end
        default: begin
          est    <= est_next;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st == S_FINAL));

  a_r3_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= SW'(M * W));

  a_r3_sum_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWEEP) |=> sum >= $past(sum));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWEEP && idx != B'(M - 1)) |=> (st == S_SWEEP && idx == $past(idx) + 1'b1));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(est)));
endmodule

// File: tb/sim_lowzero_card_est.sv
module sim_lowzero_card_est;
  localparam int  B      = 4;
  localparam int  W      = 32;
  localparam int  EW     = 32;
  localparam int  M      = 1 << B;
  localparam int  SW     = B + $clog2(W + 1);
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [B-1:0]  rd_addr;
  logic [W-1:0]  rd_data;
  logic          busy, done;
  logic [SW-1:0] obs_sum;
  logic [EW-1:0] estimate;
  logic [W-1:0]  mem [M];
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;
  assign rd_data = mem[rd_addr];

  lowzero_card_est #(.B(B), .W(W), .EW(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .obs_sum(obs_sum), .estimate(estimate));

  function automatic int obs_of(input logic [W-1:0] v);
    int n = 0;
    while (n < W && v[n]) n++;
    return n;
  endfunction

  function automatic int exp_sum();
    int s = 0;
    for (int i = 0; i < M; i++) s += obs_of(mem[i]);
    return s;
  endfunction

  function automatic real exp_est(input int s);
    int ip = s >> B;
    int fp = (s % M) >> (B - 4);
    return (2.0 ** B) / 0.77351 * (2.0 ** (ip + fp / 16.0));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] make_word(input int k);
    logic [63:0] w;
    if (k >= W) return '1;
    w = (64'd1 << k) - 64'd1;
    w = w | ({32'd0, $urandom} << (k + 1));
    return w[W-1:0];
  endfunction

  task automatic fill(input int lo, input int hi);
    for (int i = 0; i < M; i++) mem[i] = make_word($urandom_range(hi, lo));
  endtask

  task automatic sweep(input bit poke);
    int lat = 0;
    int es;
    real er, mx;
    logic [SW-1:0] s_hold;
    logic [EW-1:0] e_hold;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1 && done == 0, "R4 busy/done after start", {busy, done}, 2);
    while (!done && lat < 4 * M) begin
      @(negedge clk); lat++;
      if (poke && lat == 3) start = 1;
      if (poke && lat == 4) start = 0;
    end
    chk(lat == M + 1, poke ? "R5 latency with start during sweep" : "R4 done latency", lat, M + 1);
    chk(busy == 0, "R4 busy low at done", busy, 0);
    es = exp_sum();
    chk(obs_sum == SW'(es), "R2 R3 observable sum", obs_sum, es);
    er = exp_est(es);
    mx = 2.0 ** EW - 1.0;
    if (er > mx * 1.003)
      chk(estimate == '1, "R7 saturation", estimate, longint'(mx));
    else if (er < mx * 0.997)
      chk(real'(estimate) >= er * 0.998 - 2.0 && real'(estimate) <= er * 1.002 + 2.0,
          "R6 estimate", estimate, longint'(er));
    else chk(1'b1, "R6 R7 boundary", 0, 0);
    s_hold = obs_sum; e_hold = estimate;
    for (int i = 0; i < M; i++) mem[i] = ~mem[i];
    repeat (3) @(negedge clk);
    chk(done == 1, "R4 done held", done, 1);
    chk(obs_sum == s_hold && estimate == e_hold, "R8 results held in idle", estimate, e_hold);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL R4 watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < M; i++) mem[i] = '0;
    #(PERIOD * 3);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    chk(obs_sum == 0 && estimate == 0, "R1 reset results", estimate, 0);
    rst_n = 1;
    @(negedge clk);
    sweep(0);
    for (int i = 0; i < M; i++) mem[i] = '1;
    sweep(0);
    for (int i = 0; i < M; i++) mem[i] = make_word(27);
    sweep(0);
    for (int i = 0; i < M; i++) mem[i] = make_word(28);
    sweep(0);
    for (int i = 0; i < M; i++) mem[i] = make_word(i < M / 2 ? 3 : 2);
    sweep(0);
    for (int i = 0; i < M; i++) mem[i] = make_word(i);
    sweep(1);
    for (int r = 0; r < 12; r++) begin
      if (r % 3 == 0) fill(0, W);
      else if (r % 3 == 1) fill(4, 12);
      else fill(24, W);
      sweep(r == 5);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule